// File: doc/BRIEF.md
# PCI 64-bit Burst Write Master

This block runs a bus-master memory write burst on a 64-bit PCI bus. A local requester starts a transfer with a one-cycle start pulse, a start address and a word count. The block then asks the arbiter for the bus, drives the address phase with a 64-bit request, waits for a target to claim the cycle, and streams data words until the count is exhausted. At the end it releases the bus. If no target claims the cycle, it ends with a master abort.

On the local side, data moves through a ready/acknowledge handshake. A word is taken in any cycle where the requester's ready was high in the previous cycle and the block's acknowledge is high in the current one. One holding register sits between the local side and the PCI side, so at most one taken word can wait for the bus.

Byte enables are either latched once in the address phase or carried with each word. A mode input, sampled with the start pulse, picks between the two. A status vector tells the local side which bus phase is in progress.

Top module: `pciWr64Master`

## Requirements
- R1: After reset, and whenever idle, `reqOutN`, `frmOutN`, `wideReqN` and `mstRdyN` are 1, `adOe` is 0, `locAck` is 0 and every `statusVec` bit except bit 10 is 0.
- R2: A `startReq` pulse in idle drives `reqOutN` to 0 from the next cycle until `gntInN` is sampled 0. The address phase is the cycle after that sample.
- R3: In the address phase, `frmOutN` and `wideReqN` are both 0 and `adOe` is 1. `adOut` equals `startAddr`, and `cbeOut` equals 8'h07: upper nibble 0, memory-write command 4'b0111 in the lower nibble.
- R4: Bit 2 of `statusVec` is 1 in the address-phase cycle only if `gntInN` is still 0 in that cycle. Bit 3 is 1 in every data-state cycle. Bit 9 is 1 during the data state when `wideAckInN` was 0 in the cycle `devselInN` was first sampled 0.
- R5: `mstRdyN` stays 1 until `devselInN` has been sampled 0. When the claim arrives k cycles after the address phase (1 ≤ k ≤ 5) and a word is held, `mstRdyN` first goes to 0 k+1 cycles after the address phase.
- R6: `locXfer` is 1 exactly in cycles where `locRdy` was 1 in the previous cycle and `locAck` is 1 now. `locAckLo` and `locAckHi` equal `locXfer` in every cycle, and `locData` is taken as one 64-bit word in such a cycle.
- R7: `locAck` is 0 while the holding register has a word not yet sent, unless that word goes out on PCI in the same cycle. Words taken minus words sent never exceeds 1, so the cycle after the address phase of a zero-wait burst has `locAck` at 0.
- R8: A word is sent at each clock edge where `mstRdyN` and `tgtRdyN` are both 0. Words appear on `adOut` in the order they were taken. With the target and requester always ready, the words go out in consecutive cycles starting two cycles after the address phase.
- R9: With `beFollowWord` at 0 on the start pulse, every data phase carries on `cbeOut` the `locBe` value present during the address phase. With it at 1, each data phase carries the `locBe` value taken together with that word.
- R10: During the last data phase, `frmOutN` is 1 while `mstRdyN` is 0. In the cycle after the final handshake, `mstRdyN` and `frmOutN` are 1 and `adOe` is 0.
- R11: If `devselInN` is not sampled 0 in any of the 5 cycles after the address phase, the 6th cycle after it has `frmOutN` at 1 and `mstRdyN` at 0. No word is sent. `adOe` is 0 in the next cycle, and `statusVec` bit 10 is 1 until the next start pulse.
- R12: A burst of length N (1 to 2^LEN_W-1) takes exactly N words from the local side and sends exactly N words on PCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start pulse, accepted when idle |
| startAddr | input | DATA_W | Burst start address |
| startLen | input | LEN_W | Number of words in the burst |
| beFollowWord | input | 1 | 1: byte enables travel with each word; 0: latched in the address phase |
| locRdy | input | 1 | Local requester ready |
| locData | input | DATA_W | Local write data |
| locBe | input | DATA_W/8 | Local byte enables, active low |
| locAck | output | 1 | Master acknowledge to the local side |
| locXfer | output | 1 | Local word-taken strobe |
| locAckLo | output | 1 | Low-half data taken |
| locAckHi | output | 1 | High-half data taken |
| statusVec | output | 11 | Bit 2 address phase, bit 3 data phase, bit 9 64-bit acknowledged, bit 10 master abort |
| reqOutN | output | 1 | Bus request, active low |
| gntInN | input | 1 | Bus grant, active low |
| frmOutN | output | 1 | Cycle frame, active low |
| wideReqN | output | 1 | 64-bit transfer request, active low |
| mstRdyN | output | 1 | Initiator ready, active low |
| devselInN | input | 1 | Target claim, active low |
| tgtRdyN | input | 1 | Target ready, active low |
| wideAckInN | input | 1 | Target 64-bit acknowledge, active low |
| adOut | output | DATA_W | Address/data bus value |
| adOe | output | 1 | Drive enable for adOut and cbeOut |
| cbeOut | output | DATA_W/8 | Command / byte enables, active low |

## Verification
A wrong sequencer state shows up at the bus pins in the same cycle. FRAME, IRDY or the drive enable takes a value the phase does not allow, such as IRDY low before any claim, or FRAME still low on the last word. A corrupted holding-register flag or counter shows up within one or two cycles: a word is sent twice or skipped, the word count differs from the request, or the acknowledge stays high while a word waits. The claim timer is checked at its exact boundary. A claim in the fifth cycle must succeed, and silence must give the abort pattern in the sixth cycle.

// File: rtl/pciWr64Pkg.sv
package pciWr64Pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_CLAIM,
    S_DATA,
    S_ABORT,
    S_TURN
  } busState_e;

  localparam int ST_W    = 11;
  localparam int ST_ADDR = 2;
  localparam int ST_DATA = 3;
  localparam int ST_WIDE = 9;
  localparam int ST_ERR  = 10;

  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capStart;   // latch start address
    logic capBe;      // latch burst-wide byte enables
    logic pipeLoad;   // take a local word into the holding register
    logic selAddr;    // drive address/command instead of data
    logic busOe;      // own AD and C/BE
    logic useWordBe;  // per-word byte enables
  } dpStrobe_t;

endpackage

// File: rtl/pciWr64Dpath.sv
module pciWr64Dpath
  import pciWr64Pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] startAddr,
  input  logic [DATA_W-1:0] locData,
  input  logic [BE_W-1:0]   locBe,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [BE_W-1:0]   cbeOut
);

  logic [DATA_W-1:0] addrQ;
  logic [DATA_W-1:0] pipeData;
  logic [BE_W-1:0]   pipeBe;
  logic [BE_W-1:0]   beFixQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      pipeData <= '0;
      pipeBe   <= '0;
      beFixQ   <= '0;
    end else begin
      if (strb.capStart) addrQ <= startAddr;
      if (strb.capBe) beFixQ <= locBe;
      if (strb.pipeLoad) begin
        pipeData <= locData;
        pipeBe   <= locBe;
      end
    end
  end

  always_comb begin
    adOe   = strb.busOe;
    adOut  = '0;
    cbeOut = '0;
    if (strb.busOe) begin
      if (strb.selAddr) begin
        adOut  = addrQ;
        cbeOut = {{(BE_W-4){1'b0}}, CMD_MEM_WR};
      end else begin
        adOut  = pipeData;
        cbeOut = strb.useWordBe ? pipeBe : beFixQ;
      end
    end
  end

  // R9: in fixed mode, byte enables do not move between data cycles
  a_r9_fixed_be_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busOe && !strb.selAddr && !strb.useWordBe &&
     $past(strb.busOe && !strb.selAddr)) |-> $stable(cbeOut));

endmodule

// File: rtl/pciWr64Ctrl.sv
module pciWr64Ctrl
  import pciWr64Pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int CLAIM_MAX = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] startLen,
  input  logic             beFollowWord,
  input  logic             locRdy,
  input  logic             gntInN,
  input  logic             devselInN,
  input  logic             tgtRdyN,
  input  logic             wideAckInN,
  output logic             locAck,
  output logic             locXfer,
  output logic [ST_W-1:0]  statusVec,
  output logic             reqOutN,
  output logic             frmOutN,
  output logic             wideReqN,
  output logic             mstRdyN,
  output dpStrobe_t        strb
);

  localparam int CNT_W = $clog2(CLAIM_MAX + 1);
  localparam logic [CNT_W-1:0] CLAIM_LAST = CNT_W'(CLAIM_MAX - 1);

  busState_e        state;
  logic             pipeValid, locRdyQ, wideQ, errQ, beVarQ;
  logic [LEN_W-1:0] fetchLeft, pciLeft;
  logic [CNT_W-1:0] claimCnt;
  logic             active, pciXfer, lastPhase;

  always_comb begin
    active    = (state == S_ADDR) || (state == S_CLAIM) || (state == S_DATA);
    pciXfer   = (state == S_DATA) && pipeValid && !tgtRdyN;
    lastPhase = (state == S_DATA) && pipeValid && (pciLeft == LEN_W'(1));
    reqOutN   = !(state == S_REQ);
    frmOutN   = !((state == S_ADDR) || (state == S_CLAIM) ||
                  ((state == S_DATA) && !lastPhase));
    wideReqN  = frmOutN;
    mstRdyN   = !(((state == S_DATA) && pipeValid) || (state == S_ABORT));
    locAck    = active && (fetchLeft != '0) && (!pipeValid || pciXfer);
    locXfer   = locRdyQ && locAck;

    statusVec          = '0;
    statusVec[ST_ADDR] = (state == S_ADDR) && !gntInN;
    statusVec[ST_DATA] = (state == S_DATA);
    statusVec[ST_WIDE] = (state == S_DATA) && wideQ;
    statusVec[ST_ERR]  = errQ;

    strb.capStart  = (state == S_IDLE) && startReq;
    strb.capBe     = (state == S_ADDR);
    strb.pipeLoad  = locXfer;
    strb.selAddr   = (state == S_ADDR);
    strb.busOe     = active || (state == S_ABORT);
    strb.useWordBe = beVarQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      pipeValid <= 1'b0;
      locRdyQ   <= 1'b0;
      wideQ     <= 1'b0;
      errQ      <= 1'b0;
      beVarQ    <= 1'b0;
      fetchLeft <= '0;
      pciLeft   <= '0;
      claimCnt  <= '0;
    end else begin
      locRdyQ <= locRdy;
      if (locXfer) fetchLeft <= fetchLeft - 1'b1;
      if (pciXfer) pciLeft <= pciLeft - 1'b1;

      if (state == S_TURN) pipeValid <= 1'b0;
      else if (locXfer)    pipeValid <= 1'b1;
      else if (pciXfer)    pipeValid <= 1'b0;

      unique case (state)
        S_IDLE: if (startReq) begin
          state     <= S_REQ;
          fetchLeft <= startLen;
          pciLeft   <= startLen;
          errQ      <= 1'b0;
          wideQ     <= 1'b0;
          beVarQ    <= beFollowWord;
        end
        S_REQ:  if (!gntInN) state <= S_ADDR;
        S_ADDR: begin
          state    <= S_CLAIM;
          claimCnt <= '0;
        end
        S_CLAIM: begin
          if (!devselInN) begin
            state <= S_DATA;
            wideQ <= !wideAckInN;
          end else if (claimCnt == CLAIM_LAST) begin
            state <= S_ABORT;
            errQ  <= 1'b1;
          end else begin
            claimCnt <= claimCnt + 1'b1;
          end
        end
        S_DATA:  if (pciXfer && (pciLeft == LEN_W'(1))) state <= S_TURN;
        S_ABORT: state <= S_TURN;
        S_TURN:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: a fresh IRDY assertion inside a framed cycle follows a target claim
  a_r5_irdy_after_claim: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mstRdyN) && !frmOutN) |-> $past(!devselInN));

  // R6: the local strobe needs last cycle's ready and this cycle's acknowledge
  a_r6_xfer_rule: assert property (@(posedge clk) disable iff (!rstN)
    locXfer |-> ($past(locRdy) && locAck));

  // R7: at most one taken word waits for the bus
  a_r7_one_word_pipe: assert property (@(posedge clk) disable iff (!rstN)
    active |-> ((LEN_W+1)'(pciLeft) <= (LEN_W+1)'(fetchLeft) + 1));

  // R10: once FRAME is released, IRDY holds until the target completes
  a_r10_last_phase_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_DATA) && frmOutN && tgtRdyN) |=> (frmOutN && !mstRdyN));

  // R10: after the last handshake the control lines go idle
  a_r10_release: assert property (@(posedge clk) disable iff (!rstN)
    (pciXfer && frmOutN) |=> (frmOutN && mstRdyN));

  // R11: an unclaimed cycle ends with the abort pattern and the error bit
  a_r11_master_abort: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_CLAIM) && devselInN && (claimCnt == CLAIM_LAST)) |=>
      (frmOutN && !mstRdyN && statusVec[ST_ERR]));

endmodule

// File: rtl/pciWr64Master.sv
module pciWr64Master
  import pciWr64Pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int LEN_W     = 8,
  parameter int CLAIM_MAX = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [DATA_W-1:0]   startAddr,
  input  logic [LEN_W-1:0]    startLen,
  input  logic                beFollowWord,
  input  logic                locRdy,
  input  logic [DATA_W-1:0]   locData,
  input  logic [DATA_W/8-1:0] locBe,
  output logic                locAck,
  output logic                locXfer,
  output logic                locAckLo,
  output logic                locAckHi,
  output logic [10:0]         statusVec,
  output logic                reqOutN,
  input  logic                gntInN,
  output logic                frmOutN,
  output logic                wideReqN,
  output logic                mstRdyN,
  input  logic                devselInN,
  input  logic                tgtRdyN,
  input  logic                wideAckInN,
  output logic [DATA_W-1:0]   adOut,
  output logic                adOe,
  output logic [DATA_W/8-1:0] cbeOut
);

  localparam int BE_W = DATA_W / 8;

  dpStrobe_t strb;

  pciWr64Ctrl #(
    .LEN_W    (LEN_W),
    .CLAIM_MAX(CLAIM_MAX)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .startLen    (startLen),
    .beFollowWord(beFollowWord),
    .locRdy      (locRdy),
    .gntInN      (gntInN),
    .devselInN   (devselInN),
    .tgtRdyN     (tgtRdyN),
    .wideAckInN  (wideAckInN),
    .locAck      (locAck),
    .locXfer     (locXfer),
    .statusVec   (statusVec),
    .reqOutN     (reqOutN),
    .frmOutN     (frmOutN),
    .wideReqN    (wideReqN),
    .mstRdyN     (mstRdyN),
    .strb        (strb)
  );

  pciWr64Dpath #(
    .DATA_W(DATA_W),
    .BE_W  (BE_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .startAddr(startAddr),
    .locData  (locData),
    .locBe    (locBe),
    .adOut    (adOut),
    .adOe     (adOe),
    .cbeOut   (cbeOut)
  );

  // both halves of a 64-bit word are taken together
  assign locAckLo = locXfer;
  assign locAckHi = locXfer;

endmodule

// File: tb/pciWr64Master_bench.sv
`timescale 1ns/100ps
module pciWr64Master_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [63:0] startAddr = '0;
  logic [7:0]  startLen = '0;
  logic        beFollowWord = 1'b0;
  logic        locRdy = 1'b0;
  logic [63:0] locData = '0;
  logic [7:0]  locBe = '0;
  logic        gntInN = 1'b1, devselInN = 1'b1, tgtRdyN = 1'b1, wideAckInN = 1'b1;
  logic        locAck, locXfer, locAckLo, locAckHi;
  logic [10:0] statusVec;
  logic        reqOutN, frmOutN, wideReqN, mstRdyN, adOe;
  logic [63:0] adOut;
  logic [7:0]  cbeOut;

  always #2.5 clk = ~clk;

  pciWr64Master u_pciWr64Master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .startLen(startLen), .beFollowWord(beFollowWord), .locRdy(locRdy),
    .locData(locData), .locBe(locBe), .locAck(locAck), .locXfer(locXfer),
    .locAckLo(locAckLo), .locAckHi(locAckHi), .statusVec(statusVec),
    .reqOutN(reqOutN), .gntInN(gntInN), .frmOutN(frmOutN), .wideReqN(wideReqN),
    .mstRdyN(mstRdyN), .devselInN(devselInN), .tgtRdyN(tgtRdyN),
    .wideAckInN(wideAckInN), .adOut(adOut), .adOe(adOe), .cbeOut(cbeOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  int wdCycles = 0;

  // results of the last burst
  logic [63:0] takenD [0:15];
  logic [7:0]  takenB [0:15];
  logic [63:0] sentD  [0:15];
  logic [7:0]  sentB  [0:15];
  int rTaken, rSent, rAddrCyc, rLastCyc, rAbortCyc, rFirstXfer, rFirstIrdy, rReqLow;
  bit rDone, rIrdyEarly, rRuleBad, rLoHiBad, rPipeBad, rAckAfterAddr;
  bit rSt3Bad, rSt9All, rSt9Any, rOeAfter, rIrdyAfter, rFrmAfter, rAbortOeAfter;
  logic [63:0] rAddrAd;
  logic [7:0]  rAddrCbe, rFixedBe;
  bit rAddrWide, rSt2;

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] wordVal(input int i);
    return {32'hC0DE_0000 + 32'(i), 32'h0F0F_0000 + 32'(i * 7)};
  endfunction

  function automatic logic [7:0] beVal(input int i);
    return 8'hFF ^ (8'h01 << (i % 8));
  endfunction

  task automatic idleInputs();
    startReq = 1'b0; locRdy = 1'b0; gntInN = 1'b1;
    devselInN = 1'b1; tgtRdyN = 1'b1; wideAckInN = 1'b1;
  endtask

  task automatic runBurst(input int len, input int devDly, input logic [15:0] trdyPat,
                          input logic [15:0] rdyPat, input bit varBe, input bit wide,
                          input bit gntShort);
    bit reqPrev = 0, gntUsed = 0, claimed = 0, prevRdy = 0;
    int dataIdx = 0;
    rTaken = 0; rSent = 0; rAddrCyc = -1; rLastCyc = -1; rAbortCyc = -1;
    rFirstXfer = -1; rFirstIrdy = -1; rReqLow = 0; rDone = 0;
    rIrdyEarly = 0; rRuleBad = 0; rLoHiBad = 0; rPipeBad = 0; rAckAfterAddr = 1;
    rSt3Bad = 0; rSt9All = 1; rSt9Any = 0; rOeAfter = 1; rIrdyAfter = 0; rFrmAfter = 0;
    rAbortOeAfter = 1; rSt2 = 0; rAddrWide = 0;
    for (int cyc = 0; cyc < 100; cyc++) begin
      @(negedge clk);
      startReq     = (cyc == 0);
      startLen     = 8'(len);
      startAddr    = 64'h0000_1234_5678_9AC0 + 64'(len);
      beFollowWord = varBe;
      locRdy       = rdyPat[cyc % 16];
      locData      = wordVal(rTaken);
      locBe        = beVal(rTaken);
      gntInN       = 1'b1;
      if (reqPrev && !(gntShort && gntUsed)) begin
        gntInN = 1'b0;
        gntUsed = 1;
      end
      devselInN  = !(rAddrCyc >= 0 && rLastCyc < 0 && devDly > 0 && (cyc - rAddrCyc) >= devDly);
      tgtRdyN    = !(!devselInN && trdyPat[dataIdx % 16]);
      wideAckInN = !(!devselInN && wide);
      #1;
      if (!reqOutN) rReqLow++;
      if (!frmOutN && rAddrCyc < 0) begin
        rAddrCyc = cyc; rAddrAd = adOut; rAddrCbe = cbeOut;
        rAddrWide = !wideReqN; rSt2 = statusVec[2]; rFixedBe = locBe;
      end
      if (rAddrCyc >= 0 && cyc == rAddrCyc + 1) rAckAfterAddr = locAck;
      if (!mstRdyN && !claimed && devDly > 0) rIrdyEarly = 1;
      if (!mstRdyN && rFirstIrdy < 0 && devDly > 0) rFirstIrdy = cyc;
      if (locAckLo !== locXfer || locAckHi !== locXfer) rLoHiBad = 1;
      if (locXfer) begin
        if (!(prevRdy && locAck)) rRuleBad = 1;
        if (rTaken < 16) begin takenD[rTaken] = locData; takenB[rTaken] = locBe; end
        rTaken++;
      end else if (prevRdy && locAck) rRuleBad = 1;
      if (!mstRdyN && !tgtRdyN) begin
        if (rSent < 16) begin sentD[rSent] = adOut; sentB[rSent] = cbeOut; end
        if (rFirstXfer < 0) rFirstXfer = cyc;
        if (!statusVec[3]) rSt3Bad = 1;
        if (statusVec[9]) rSt9Any = 1; else rSt9All = 0;
        rSent++;
        if (frmOutN) rLastCyc = cyc;
      end
      if (rTaken - rSent > 1) rPipeBad = 1;
      if (rLastCyc >= 0 && cyc == rLastCyc + 1) begin
        rOeAfter = adOe; rIrdyAfter = mstRdyN; rFrmAfter = frmOutN;
      end
      if (devDly == 0 && rAddrCyc >= 0 && rAbortCyc < 0 && frmOutN && !mstRdyN) rAbortCyc = cyc;
      if (rAbortCyc >= 0 && cyc == rAbortCyc + 1) rAbortOeAfter = adOe;
      if (!devselInN) begin dataIdx++; claimed = 1; end
      prevRdy = locRdy;
      reqPrev = !reqOutN;
      if ((rLastCyc >= 0 && cyc >= rLastCyc + 2) || (rAbortCyc >= 0 && cyc >= rAbortCyc + 2)) begin
        rDone = 1;
        break;
      end
    end
    @(negedge clk);
    idleInputs();
    #1;
  endtask

  task automatic checkOrder(input string tag, input int len, input bit varBe);
    for (int i = 0; i < len && i < 16; i++) begin
      chkEq({tag, " R8 word order"}, sentD[i], wordVal(i));
      chkEq({tag, " R9 byte enables"}, 64'(sentB[i]), 64'(varBe ? beVal(i) : rFixedBe));
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    idleInputs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chkEq("R1 reset reqOutN", 64'(reqOutN), 64'd1);
    chkEq("R1 reset frmOutN/wideReqN/mstRdyN", 64'({frmOutN, wideReqN, mstRdyN}), 64'h7);
    chkEq("R1 reset adOe/locAck", 64'({adOe, locAck}), 64'h0);
    chkEq("R1 reset status", 64'(statusVec), 64'h0);
  endtask

  task automatic testBasic(input string tag);
    runBurst(4, 1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b0);
    chkEq({tag, " R12 run finished"}, 64'(rDone), 64'd1);
    chkEq({tag, " R2 request cycles"}, 64'(rReqLow), 64'd2);
    chkEq({tag, " R2 address phase cycle"}, 64'(rAddrCyc), 64'd3);
    chkEq({tag, " R3 address"}, rAddrAd, 64'h0000_1234_5678_9AC4);
    chkEq({tag, " R3 command"}, 64'(rAddrCbe), 64'h07);
    chkEq({tag, " R3 64-bit request"}, 64'(rAddrWide), 64'd1);
    chkEq({tag, " R4 address status"}, 64'(rSt2), 64'd1);
    chkEq({tag, " R4 data status"}, 64'(rSt3Bad), 64'd0);
    chkEq({tag, " R4 wide status"}, 64'(rSt9All), 64'd1);
    chkEq({tag, " R5 first IRDY"}, 64'(rFirstIrdy - rAddrCyc), 64'd2);
    chkEq({tag, " R5 IRDY before claim"}, 64'(rIrdyEarly), 64'd0);
    chkEq({tag, " R6 strobe rule"}, 64'(rRuleBad), 64'd0);
    chkEq({tag, " R6 half acks"}, 64'(rLoHiBad), 64'd0);
    chkEq({tag, " R7 ack after address"}, 64'(rAckAfterAddr), 64'd0);
    chkEq({tag, " R7 pipeline depth"}, 64'(rPipeBad), 64'd0);
    chkEq({tag, " R8 zero-wait streaming"}, 64'(rLastCyc - rFirstXfer), 64'd3);
    chkEq({tag, " R12 words taken"}, 64'(rTaken), 64'd4);
    chkEq({tag, " R12 words sent"}, 64'(rSent), 64'd4);
    checkOrder(tag, 4, 1'b0);
    chkEq({tag, " R10 release IRDY/FRAME"}, 64'({rIrdyAfter, rFrmAfter}), 64'h3);
    chkEq({tag, " R10 tristate after last"}, 64'(rOeAfter), 64'd0);
    chkEq({tag, " R11 no error bit"}, 64'(statusVec[10]), 64'd0);
    chkEq({tag, " R1 idle after"}, 64'({reqOutN, frmOutN, mstRdyN, adOe, locAck}), 64'h1C);
  endtask

  task automatic testStall();
    runBurst(6, 2, 16'b1011_0110_1101_0110, 16'b1101_1011_0111_0101, 1'b1, 1'b0, 1'b0);
    chkEq("stall R12 run finished", 64'(rDone), 64'd1);
    chkEq("stall R12 words taken", 64'(rTaken), 64'd6);
    chkEq("stall R12 words sent", 64'(rSent), 64'd6);
    chkEq("stall R7 pipeline depth", 64'(rPipeBad), 64'd0);
    chkEq("stall R6 strobe rule", 64'(rRuleBad), 64'd0);
    chkEq("stall R6 half acks", 64'(rLoHiBad), 64'd0);
    chkEq("stall R5 IRDY before claim", 64'(rIrdyEarly), 64'd0);
    chkEq("stall R4 wide status without ACK64", 64'(rSt9Any), 64'd0);
    checkOrder("stall", 6, 1'b1);
    chkEq("stall R10 tristate after last", 64'(rOeAfter), 64'd0);
  endtask

  task automatic testSlowClaim();
    runBurst(2, 5, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b0);
    chkEq("slow R11 fifth-cycle claim not aborted", 64'(rAbortCyc < 0), 64'd1);
    chkEq("slow R5 IRDY before claim", 64'(rIrdyEarly), 64'd0);
    chkEq("slow R5 first IRDY", 64'(rFirstIrdy - rAddrCyc), 64'd6);
    chkEq("slow R12 words sent", 64'(rSent), 64'd2);
    checkOrder("slow", 2, 1'b0);
    chkEq("slow R11 no error bit", 64'(statusVec[10]), 64'd0);
  endtask

  task automatic testAbort();
    runBurst(3, 0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b0);
    chkEq("abort R11 abort cycle offset", 64'(rAbortCyc - rAddrCyc), 64'd6);
    chkEq("abort R11 no words sent", 64'(rSent), 64'd0);
    chkEq("abort R11 tristate next cycle", 64'(rAbortOeAfter), 64'd0);
    chkEq("abort R11 error bit held", 64'(statusVec[10]), 64'd1);
    chkEq("abort R1 idle lines", 64'({reqOutN, frmOutN, mstRdyN, adOe}), 64'hE);
  endtask

  task automatic testShortGrant();
    runBurst(1, 1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1);
    chkEq("short R2 address phase cycle", 64'(rAddrCyc), 64'd3);
    chkEq("short R4 address status suppressed", 64'(rSt2), 64'd0);
    chkEq("short R10 single word frame released", 64'(rLastCyc), 64'(rFirstXfer));
    chkEq("short R12 words sent", 64'(rSent), 64'd1);
    checkOrder("short", 1, 1'b0);
    chkEq("short R10 tristate after last", 64'(rOeAfter), 64'd0);
  endtask

  initial begin
    testReset();
    testBasic("basic");
    testStall();
    testSlowClaim();
    testAbort();
    testBasic("after-abort");
    testShortGrant();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    wdCycles++;
    if (wdCycles > 20000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", wdCycles);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule